// File: doc/BRIEF.md
# Latched Interrupt Controller with Write Acknowledge

This block gathers up to 32 interrupt sources into a register of pending bits and drives one request line toward a processor. Each source is latched into its pending bit when it fires, whether or not the source is currently enabled. The request line is raised while any pending bit is also enabled. Enables are held in an active-low mask: a 0 in a mask bit lets that source through, and a 1 blocks it.

Software reaches the block over a plain 32-bit register bus made of address, write enable, write data and combinational read data. The mask register sits at byte offset 0xA0 and the pending register at byte offset 0xA4. A pending bit never clears by itself. Software acknowledges it in one of two ways. It can write 0 into that bit of the pending register. It can also write the mask register, and that write clears every pending bit the written value enables, even when the value equals the one already held.

Each source is either edge-triggered, latching on a rising input, or level-triggered, latching on every cycle the input is high. A per-bit parameter chooses between the two.

Top module: `irq_latch_ctrl`

## Requirements
- R1: The mask register is at offset 0xA0 and reads back the last value written there. Its reset value is all ones. A mask bit of 0 enables that source and a mask bit of 1 disables it.
- R2: The pending register is at offset 0xA4 and reads back the latched pending bit of every source, with bit i belonging to source i. Its reset value is zero.
- R3: A write to offset 0xA4 clears each pending bit whose write-data bit is 0. It leaves each pending bit whose write-data bit is 1 unchanged.
- R4: A pending bit stays set until software acknowledges it through R3 or R5. No other condition clears it.
- R5: A write to offset 0xA0 clears each pending bit whose write-data bit is 0, including when the written value equals the current mask. Pending bits whose write-data bit is 1 are unchanged.
- R6: `irq_out` is low after reset. Whenever the pending bits and mask change, `irq_out` becomes, one clock later, the OR over all bits of (pending AND NOT mask).
- R7: A source event sets its pending bit whatever that source's mask bit is.
- R8: If a source event and an acknowledge of the same bit fall in the same cycle, the bit is set after that cycle.
- R9: A read of any offset other than 0xA0 or 0xA4 returns zero. A write to any other offset changes neither register.
- R10: A source whose `LEVEL_SEL` bit is 0 raises an event only on the clock where its input is high and was low on the previous clock. A source whose `LEVEL_SEL` bit is 1 raises an event on every clock where its input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | NUM_SRC | Interrupt source inputs |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC = 32 and LEVEL_SEL = 32'hF000_0000, with the offsets left at their defaults. The four top sources are therefore level-triggered and the rest are edge-triggered, so both trigger kinds are exercised across the full 32-bit register width. With this build, a level source held high while it is acknowledged re-pends in the same cycle, and an edge source held high stays cleared. A long random phase also drives acknowledges to the mask and pending registers, and to unmapped offsets, while sources fire. This puts event-versus-acknowledge collisions on enabled bits and on disabled bits within reach.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]  MASK_OFS  = 'hA0,
  parameter logic [ADDR_W-1:0]  STAT_OFS  = 'hA4,
  parameter logic [NUM_SRC-1:0] LEVEL_SEL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);

  logic [NUM_SRC-1:0] mask_q, stat_q, src_q, evt, ack;
  logic               hit_mask, hit_stat, irq_q;

  assign hit_mask = bus_addr == MASK_OFS;
  assign hit_stat = bus_addr == STAT_OFS;
  assign evt      = src & (LEVEL_SEL | ~src_q);
  assign ack      = (bus_we && (hit_mask || hit_stat)) ? ~bus_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      stat_q <= '0;
      src_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      src_q  <= src;
      stat_q <= (stat_q & ~ack) | evt;
      irq_q  <= |(stat_q & ~mask_q);
      if (bus_we && hit_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_mask)      bus_rdata[NUM_SRC-1:0] = mask_q;
    else if (hit_stat) bus_rdata[NUM_SRC-1:0] = stat_q;
  end

  assign irq_out = irq_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && hit_mask) |=> $stable(mask_q)); // R1
  AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_stat) |=> ((stat_q & $past(stat_q & bus_wdata[NUM_SRC-1:0])) == $past(stat_q & bus_wdata[NUM_SRC-1:0]))); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_out); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & ack)) |=> ((stat_q & $past(evt)) == $past(evt))); // R8
  always_comb begin
    if (!hit_mask && !hit_stat) AST_UNMAPPED_ZERO: assert (bus_rdata == '0); // R9
  end

endmodule

// File: tb/irq_latch_ctrl_test.sv
`timescale 1ns/1ps
module irq_latch_ctrl_test;
  localparam logic [31:0] LVL = 32'hF000_0000;

  logic clk = 0, rst_n = 0, bus_we = 0, irq_out;
  logic [31:0] src = 0, bus_wdata = 0, bus_rdata;
  logic [7:0]  bus_addr = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_mask, m_stat, m_prev;
  logic        m_irq;

  irq_latch_ctrl #(.NUM_SRC(32), .ADDR_W(8), .LEVEL_SEL(LVL)) uut (
    .clk(clk), .rst_n(rst_n), .src(src), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'hA0) return m_mask;
    if (a == 8'hA4) return m_stat;
    return 32'h0;
  endfunction

  task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] wd,
                     input logic [31:0] s, input string tag);
    logic [31:0] evt, clr;
    bus_addr = a; bus_we = we; bus_wdata = wd; src = s;
    #1;
    chk({tag, " read"}, bus_rdata, model_read(a));
    @(posedge clk);
    evt   = s & (LVL | ~m_prev);
    clr   = (we && (a == 8'hA0 || a == 8'hA4)) ? ~wd : 32'h0;
    m_irq = |(m_stat & ~m_mask);
    m_stat = (m_stat & ~clr) | evt;
    if (we && a == 8'hA0) m_mask = wd;
    m_prev = s;
    #1;
    chk({tag, " irq"}, {31'b0, irq_out}, {31'b0, m_irq});
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] s, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_we = 0; src = s;
    #1;
    chk({tag, " direct"}, bus_rdata, exp);
    cyc(a, 0, 0, s, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_mask = '1; m_stat = '0; m_prev = '0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset irq", {31'b0, irq_out}, 32'h0);
    rst_n = 1;
    rd(8'hA0, 0, 32'hFFFF_FFFF, "R1 reset mask");
    rd(8'hA4, 0, 32'h0, "R2 reset status");
    // R7: event latched while disabled, no request
    cyc(8'h00, 0, 0, 32'h8, "R7 pulse");
    rd(8'hA4, 0, 32'h8, "R7 latched masked");
    chk("R6 masked no irq", {31'b0, irq_out}, 32'h0);
    // R5: mask write enabling bits 0 and 3 acknowledges bit 3
    cyc(8'hA0, 1, 32'hFFFF_FFF6, 0, "R5 mask write");
    rd(8'hA4, 0, 32'h0, "R5 ack by mask");
    rd(8'hA0, 0, 32'hFFFF_FFF6, "R1 mask readback");
    // R6: enabled event raises irq one clock after status sets
    cyc(8'hA4, 0, 0, 32'h1, "R6 event");
    chk("R6 irq lags", {31'b0, irq_out}, 32'h0);
    cyc(8'hA4, 0, 0, 0, "R6 rise");
    chk("R6 irq high", {31'b0, irq_out}, 32'h1);
    repeat (4) cyc(8'h10, 0, 0, 0, "R4 hold");
    rd(8'hA4, 0, 32'h1, "R4 still pending");
    chk("R4 irq held", {31'b0, irq_out}, 32'h1);
    cyc(8'hA4, 1, 32'hFFFF_FFFF, 0, "R3 write ones");
    rd(8'hA4, 0, 32'h1, "R3 ones keep");
    cyc(8'hA4, 1, 32'hFFFF_FFFE, 0, "R3 write zero");
    rd(8'hA4, 0, 32'h0, "R3 zero clears");
    cyc(8'h10, 0, 0, 0, "R6 fall");
    chk("R6 irq low", {31'b0, irq_out}, 32'h0);
    // R5: same mask value rewritten still acknowledges
    cyc(8'h10, 0, 0, 32'h29, "R5 events");
    rd(8'hA4, 0, 32'h29, "R5 before");
    cyc(8'hA0, 1, 32'hFFFF_FFF6, 0, "R5 same value");
    rd(8'hA4, 0, 32'h20, "R5 disabled bit kept");
    // R8: event and acknowledge of the same bit in one cycle
    cyc(8'hA4, 1, 32'hFFFF_FFDE, 32'h1, "R8 collide");
    rd(8'hA4, 0, 32'h1, "R8 event wins");
    // R9: unmapped offsets
    cyc(8'hA8, 1, 32'h0, 0, "R9 write");
    rd(8'hA4, 0, 32'h1, "R9 status untouched");
    rd(8'hA0, 0, 32'hFFFF_FFF6, "R9 mask untouched");
    rd(8'hA8, 0, 32'h0, "R9 read zero");
    // R10: level bit 28 re-pends while high, edge bit 1 does not
    cyc(8'hA4, 1, 32'h0, 32'h1000_0002, "R10 raise");
    rd(8'hA4, 32'h1000_0002, 32'h1000_0002, "R10 both set");
    cyc(8'hA4, 1, 32'h0, 32'h1000_0002, "R10 ack");
    rd(8'hA4, 32'h1000_0002, 32'h1000_0000, "R10 level repends");
    cyc(8'hA4, 1, 32'h0, 0, "R10 drop");
    rd(8'hA4, 0, 32'h0, "R10 cleared");
    // random phase against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'hA0; 1: a = 8'hA4; 2: a = 8'hA8; default: a = 8'h00;
      endcase
      cyc(a, ($urandom_range(0, 3) == 0), $urandom | $urandom, $urandom & $urandom & $urandom,
          "R4 R5 R8 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule